// File: doc/BRIEF.md
# Mode-Gated Pin Function Select Register

This block holds an 8-bit control register. Each implemented bit chooses whether a port pin carries a bus-control function or stays general-purpose I/O. Five bits are implemented and they steer six pins: the free-cycle indicator, the two pipe-status pins, the external clock, the low byte strobe and the read/write line. Software writes the register through a simple write strobe with write data. A read strobe returns the stored value.

A 3-bit operating-mode input affects the block in two ways. It sets the write policy for each bit: write once, write anytime or write never. It also gates each function select, so a pin that has no meaning in the current mode falls back to general-purpose I/O. Only reset clears the record of which bits have used their single permitted write. Pin drivers and bus-cycle generation sit outside the block and consume the `pinBusSel` vector.

Mode codes: 0 single-chip, 1 normal expanded wide, 2 normal expanded narrow, 3 emulation, 4 special, 5 special peripheral, 6 and 7 reserved.

Top module: `pinmux_ctrl_reg`

## Requirements
- R1: Register layout. Bit 7 is the free-cycle disable (1 = GPIO). Bit 5 is the pipe-status enable (1 = bus). Bit 4 is the external-clock disable (1 = GPIO). Bit 3 is the low-strobe enable (1 = bus). Bit 2 is the read/write enable (1 = bus). Bits 6, 1 and 0 always hold 0 and ignore writes. The reset value is 0x80.
- R2: When `rdEn` is 1, `rdData` equals the stored register in every mode. When `rdEn` is 0, `rdData` is 0.
- R3: In modes 0, 1 and 2, bits 7, 5, 3 and 2 take only the first write after reset. Later writes leave them unchanged. A write counts as the permitted write even when it stores the same value.
- R4: Bit 4 takes every write made in modes 0, 1, 2, 4 and 5.
- R5: A write in mode 3 (emulation), or in the reserved modes 6 and 7, changes no bit.
- R6: In modes 4 and 5, every implemented bit takes every write. Writes made in these modes do not use up the single normal-mode write.
- R7: Output `pinBusSel[k]` is 1 when pin k carries its bus function:
  - pin 7 = !bit7
  - pins 6 and 5 = bit5
  - pin 4 = !bit4
  - pin 3 = bit3
  - pin 2 = bit2

  Pins 7, 6, 5, 3 and 2 are also subject to the mode gating in R8. Pin 4 is not gated in any mode.
- R8: Pins 7, 6, 5, 3 and 2 are forced to GPIO in modes 0, 5, 6 and 7. Pin 3 is also forced to GPIO in mode 2.
- R9: Pins 6 and 5 always select the same function.
- R10: Only reset clears the write-once tracking. After a reset, the next normal-mode write loads bits 7, 5, 3 and 2 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| mode | input | 3 | Operating-mode code |
| rdData | output | 8 | Register readback, 0 when not reading |
| pinBusSel | output | 6 | Index 7 down to 2: 1 = pin carries bus function |

## Verification
The assertions assume that `mode` is stable around each clock edge. They also assume that a write strobe held high for several cycles counts as one write per cycle. Under those assumptions, the write-once flags become set on the first normal-mode write, and every later edge is a policy check. The stimulus changes `mode`, `wrEn` and `wrData` only at falling edges, and it draws modes from all eight codes, including the reserved ones. Occasional resets re-arm the write-once path, so locked and open states both recur many times.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int REG_W  = 8;
  localparam int MODE_W = 3;

  // Bit positions of the implemented controls.
  localparam int B_FREE = 7;
  localparam int B_PIPE = 5;
  localparam int B_CLK  = 4;
  localparam int B_LSTB = 3;
  localparam int B_RW   = 2;

  localparam logic [REG_W-1:0] IMPL_MASK    = (REG_W'(1) << B_FREE) | (REG_W'(1) << B_PIPE) |
                                              (REG_W'(1) << B_CLK)  | (REG_W'(1) << B_LSTB) |
                                              (REG_W'(1) << B_RW);
  localparam logic [REG_W-1:0] ONCE_MASK    = IMPL_MASK & ~(REG_W'(1) << B_CLK);
  localparam logic [REG_W-1:0] ANYTIME_MASK = REG_W'(1) << B_CLK;
  localparam logic [REG_W-1:0] RESET_VAL    = REG_W'(1) << B_FREE;

  typedef enum logic [MODE_W-1:0] {
    MODE_SC   = 3'd0,
    MODE_NXW  = 3'd1,
    MODE_NXN  = 3'd2,
    MODE_EMU  = 3'd3,
    MODE_SPC  = 3'd4,
    MODE_SPP  = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } opMode_e;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic [REG_W-1:0] loadMask;   // bits to load this cycle
    logic             gateBus;    // bus functions allowed on pins 7,6,5,2
    logic             gateStrobe; // bus function allowed on pin 3
  } ctlStrobe_s;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] mode,
  output ctlStrobe_s        strb,
  output logic [REG_W-1:0]  onceUsed
);
  opMode_e modeE;
  logic isNormal;
  logic isSpecial;
  logic [REG_W-1:0] canWrite;

  assign modeE = opMode_e'(mode);

  always_comb begin
    isNormal        = 1'b0;
    isSpecial       = 1'b0;
    strb.gateBus    = 1'b0;
    strb.gateStrobe = 1'b0;
    unique case (modeE)
      MODE_SC:  begin isNormal = 1'b1; end
      MODE_NXW: begin isNormal = 1'b1; strb.gateBus = 1'b1; strb.gateStrobe = 1'b1; end
      MODE_NXN: begin isNormal = 1'b1; strb.gateBus = 1'b1; end
      MODE_EMU: begin strb.gateBus = 1'b1; strb.gateStrobe = 1'b1; end
      MODE_SPC: begin isSpecial = 1'b1; strb.gateBus = 1'b1; strb.gateStrobe = 1'b1; end
      MODE_SPP: begin isSpecial = 1'b1; end
      default:  begin end
    endcase
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (ONCE_MASK[i]) begin : g_once
      logic usedFlag;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  usedFlag <= 1'b0;
        else if (wrEn && isNormal)  usedFlag <= 1'b1;
      end
      assign onceUsed[i] = usedFlag;
      assign canWrite[i] = isSpecial || (isNormal && !usedFlag);
    end else if (IMPL_MASK[i]) begin : g_any
      assign onceUsed[i] = 1'b0;
      assign canWrite[i] = isSpecial || (isNormal && ANYTIME_MASK[i]);
    end else begin : g_none
      assign onceUsed[i] = 1'b0;
      assign canWrite[i] = 1'b0;
    end
  end

  assign strb.loadMask = wrEn ? canWrite : '0;
endmodule

// File: rtl/pinmux_dpath.sv
module pinmux_dpath
  import pinmux_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [REG_W-1:0]   wrData,
  input  logic               rdEn,
  input  ctlStrobe_s         strb,
  output logic [REG_W-1:0]   regVal,
  output logic [REG_W-1:0]   rdData,
  output logic [B_FREE:B_RW] pinBusSel
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regVal <= RESET_VAL;
    else       regVal <= (regVal & ~strb.loadMask) | (wrData & strb.loadMask);
  end

  assign rdData = rdEn ? regVal : '0;

  always_comb begin
    pinBusSel          = '0;
    pinBusSel[B_FREE]  = strb.gateBus    & ~regVal[B_FREE];
    pinBusSel[B_PIPE+1] = strb.gateBus   &  regVal[B_PIPE];
    pinBusSel[B_PIPE]  = strb.gateBus    &  regVal[B_PIPE];
    pinBusSel[B_CLK]   = ~regVal[B_CLK];
    pinBusSel[B_LSTB]  = strb.gateStrobe &  regVal[B_LSTB];
    pinBusSel[B_RW]    = strb.gateBus    &  regVal[B_RW];
  end
endmodule

// File: rtl/pinmux_ctrl_reg.sv
module pinmux_ctrl_reg
  import pinmux_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               rdEn,
  input  logic [MODE_W-1:0]  mode,
  output logic [REG_W-1:0]   rdData,
  output logic [B_FREE:B_RW] pinBusSel
);
  ctlStrobe_s       strb;
  logic [REG_W-1:0] regVal;
  logic [REG_W-1:0] onceUsed;

  pinmux_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .mode(mode),
    .strb(strb), .onceUsed(onceUsed)
  );

  pinmux_dpath dpath_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .rdEn(rdEn), .strb(strb),
    .regVal(regVal), .rdData(rdData), .pinBusSel(pinBusSel)
  );
endmodule

// File: rtl/pinmux_ctrl_reg_chk.sv
module pinmux_ctrl_reg_chk
  import pinmux_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic [MODE_W-1:0]  mode,
  input logic [REG_W-1:0]   regVal,
  input logic [REG_W-1:0]   onceUsed,
  input logic [B_FREE:B_RW] pinBusSel
);
  logic isNorm, isSpec, gatedOff;
  assign isNorm   = (mode <= 3'd2);
  assign isSpec   = (mode == 3'd4) || (mode == 3'd5);
  assign gatedOff = (mode == 3'd0) || (mode == 3'd5) || (mode >= 3'd6);

  a_r1_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regVal & ~IMPL_MASK) == '0);

  a_r3_once_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isNorm && ((onceUsed & ONCE_MASK) == ONCE_MASK))
      |=> ((regVal & ONCE_MASK) == $past(regVal & ONCE_MASK)));

  a_r4_clk_anytime: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (isNorm || isSpec)) |=> (regVal[B_CLK] == $past(wrData[B_CLK])));

  a_r5_emul_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 || mode >= 3'd6) |=> $stable(regVal));

  a_r6_special_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isSpec) |=> (regVal == ($past(wrData) & IMPL_MASK)));

  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    gatedOff |-> (pinBusSel[7] == 1'b0 && pinBusSel[6] == 1'b0 &&
                  pinBusSel[5] == 1'b0 && pinBusSel[3] == 1'b0 && pinBusSel[2] == 1'b0));

  a_r8_narrow_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2) |-> !pinBusSel[3]);

  a_r9_pipe_pair: assert property (@(posedge clk) disable iff (!rstN)
    pinBusSel[6] == pinBusSel[5]);

  a_r10_once_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(onceUsed) & ~onceUsed) == '0);
endmodule

bind pinmux_ctrl_reg pinmux_ctrl_reg_chk chk_i (.*);

// File: tb/pinmux_ctrl_reg_tb.sv
module pinmux_ctrl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [2:0] mode = 3'd1;
  logic [7:0] rdData;
  logic [7:2] pinBusSel;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] mReg = 8'h80;
  bit         mUsed = 1'b0;

  always #5 clk = ~clk;

  pinmux_ctrl_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .mode(mode), .rdData(rdData), .pinBusSel(pinBusSel)
  );

  function automatic logic [7:2] expPins(input logic [2:0] m, input logic [7:0] r);
    logic gA, gL;
    logic [7:2] p;
    gA = !(m == 3'd0 || m == 3'd5 || m >= 3'd6);
    gL = gA && (m != 3'd2);
    p[7] = gA & ~r[7];
    p[6] = gA & r[5];
    p[5] = gA & r[5];
    p[4] = ~r[4];
    p[3] = gL & r[3];
    p[2] = gA & r[2];
    return p;
  endfunction

  task automatic modelWrite(input logic [2:0] m, input logic [7:0] d);
    if (m <= 3'd2) begin
      mReg[4] = d[4];
      if (!mUsed) begin
        mReg[7] = d[7]; mReg[5] = d[5]; mReg[3] = d[3]; mReg[2] = d[2];
      end
      mUsed = 1'b1;
    end else if (m == 3'd4 || m == 3'd5) begin
      mReg = d & 8'hBC;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mReg = 8'h80; mUsed = 1'b0;
  endtask

  task automatic doOp(input logic [2:0] m, input logic w, input logic r,
                      input logic [7:0] d, input string tag);
    logic [7:0] expRd;
    logic [7:2] expP;
    @(negedge clk);
    mode = m; wrEn = w; rdEn = r; wrData = d;
    @(posedge clk);
    if (w) modelWrite(m, d);
    #2;
    expRd = r ? mReg : 8'h00;
    expP = expPins(m, mReg);
    check(rdData == expRd, {tag, " R2 readback"}, rdData, expRd);
    check(pinBusSel == expP, {tag, " R7 pins"}, {2'b00, pinBusSel}, {2'b00, expP});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    doOp(3'd1, 1'b0, 1'b1, 8'h00, "R1 reset value");
    check(rdData == 8'h80, "R1 reset 0x80", rdData, 8'h80);
    doOp(3'd1, 1'b0, 1'b0, 8'h00, "R2 no read");
    doOp(3'd1, 1'b1, 1'b1, 8'hFF, "R1 R3 first write");
    check(rdData == 8'hBC, "R1 unimplemented bits zero", rdData, 8'hBC);
    doOp(3'd1, 1'b1, 1'b1, 8'h00, "R3 R4 second write");
    check(rdData == 8'hAC, "R3 locked, R4 clk bit written", rdData, 8'hAC);
    doOp(3'd2, 1'b1, 1'b1, 8'h10, "R4 R8 narrow");
    check(pinBusSel[3] == 1'b0, "R8 narrow strobe gated", {7'd0, pinBusSel[3]}, 8'h00);
    doOp(3'd3, 1'b1, 1'b1, 8'h00, "R5 emulation write");
    check(rdData == 8'hBC, "R5 emulation frozen", rdData, 8'hBC);
    doOp(3'd6, 1'b1, 1'b1, 8'h00, "R5 reserved write");
    doOp(3'd4, 1'b1, 1'b1, 8'h43, "R6 special write");
    check(rdData == 8'h00, "R6 special loads all", rdData, 8'h00);
    doOp(3'd1, 1'b1, 1'b1, 8'hFF, "R3 still locked after special");
    doOp(3'd5, 1'b1, 1'b1, 8'hFF, "R6 R8 special peripheral");
    check(pinBusSel == 6'b000000, "R8 special peripheral gated", {2'b00, pinBusSel}, 8'h00);
    doOp(3'd0, 1'b0, 1'b1, 8'h00, "R8 single-chip");
    doOp(3'd1, 1'b0, 1'b1, 8'h00, "R9 pipe pair");
    check(pinBusSel[6] == pinBusSel[5] && pinBusSel[5], "R9 both pipe pins",
          {6'd0, pinBusSel[6:5]}, 8'h03);
    doReset();
    doOp(3'd4, 1'b1, 1'b1, 8'h24, "R6 special not consuming");
    doOp(3'd1, 1'b1, 1'b1, 8'h88, "R10 R3 once open");
    check(rdData == 8'h88, "R10 open after reset", rdData, 8'h88);
    doOp(3'd1, 1'b1, 1'b1, 8'h24, "R3 locked");
    doReset();
    doOp(3'd1, 1'b1, 1'b1, 8'h80, "R3 same-value write");
    doOp(3'd1, 1'b1, 1'b1, 8'h2C, "R3 same-value consumed");
    check(rdData == 8'h80, "R3 same value counts", rdData, 8'h80);
    doReset();
    doOp(3'd2, 1'b1, 1'b1, 8'h2C, "R10 reload");
    check(rdData == 8'h2C, "R10 reload after reset", rdData, 8'h2C);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[31:26] == 6'd0) doReset();
      else doOp(rv[2:0], rv[3], rv[4] | rv[5], rv[15:8], "random R3 R4 R5 R6");
    end

    @(negedge clk);
    wrEn = 1'b0;
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule